// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Split Read

This block is a 12-bit up-counter that advances by one on every cycle where the tick enable is high. The tick is meant to arrive once per microsecond from a prescaler outside the block, so the count covers roughly four milliseconds before it wraps. The block also decodes two periodic interrupt pulses from the count. The short one fires every 128 ticks and the long one fires every 1024 ticks.

Software reads the count through two byte-wide read-only registers. A read of the low register at address 0x24 returns count bits 7:0. The same read copies count bits 11:8 into a holding register. A later read of the high register at address 0x25 returns the held nibble in bits 3:0, not the live counter. A 12-bit value assembled from the two reads is therefore consistent, however far apart the reads are.

A read is a one-cycle strobe carrying an address. Every strobe is accepted, and there is no ready signal or back-pressure. The data comes back exactly one cycle later and is qualified by a one-cycle valid pulse. The data output holds its last value between reads.

Top module: `usec_timer`

## Requirements
- R1: After reset the counter and the holding nibble are 0, both interrupt outputs are low, and the read valid output is low.
- R2: The counter increments by one on each clock edge where `tick_i` is high, and otherwise holds its value.
- R3: From 0xFFF the counter wraps to 0x000 on the next tick.
- R4: `irq_short_o` is high for exactly one cycle, in the cycle right after a tick that takes the low 7 count bits to 0. This gives one pulse per 128 ticks.
- R5: `irq_long_o` is high for exactly one cycle, in the cycle right after a tick that takes the low 10 count bits to 0. This gives one pulse per 1024 ticks. Every long pulse coincides with a short pulse.
- R6: A read strobe at address 0x24 returns, one cycle later, count bits 7:0 as they stood in the strobe cycle, before any tick in that same cycle is applied.
- R7: A read strobe at address 0x24 copies count bits 11:8, as they stood in the strobe cycle, into the holding nibble.
- R8: A read strobe at address 0x25 returns the holding nibble in data bits 3:0, with bits 7:4 at 0. The holding nibble changes only on a 0x24 read.
- R9: A read strobe at any other address returns 0 and changes no state.
- R10: `rd_valid_o` is high exactly one cycle after each read strobe and low otherwise. Strobes on back-to-back cycles are all served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one cycle per microsecond |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | One cycle after each read strobe |
| irq_short_o | output | 1 | 128-tick interrupt pulse |
| irq_long_o | output | 1 | 1024-tick interrupt pulse |

## Verification
A counter that slips or skips a tick shows up at the next 0x24 read. It also moves the next interrupt pulse, which can take up to 128 ticks to reveal an error in the low bits. A corrupted or stale holding nibble stays hidden until a 0x25 read follows. Wrap faults appear only after 4096 ticks, so the bench drives the counter through complete wraps.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int unsigned CNT_W      = 12;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned SHORT_BITS = 7;
  localparam int unsigned LONG_BITS  = 10;
  localparam logic [ADDR_W-1:0] ADDR_LO = 8'h24;
  localparam logic [ADDR_W-1:0] ADDR_HI = 8'h25;

  typedef enum logic [1:0] {SEL_NONE, SEL_LO, SEL_HI} rd_sel_e;
endpackage

// File: rtl/usec_timer_counter.sv
module usec_timer_counter #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SHORT_BITS = 7,
  parameter int unsigned LONG_BITS  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_short_o,
  output logic             irq_long_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             short_q, long_q;
  logic             short_roll, long_roll;

  always_comb begin
    short_roll = tick_i && (cnt_q[SHORT_BITS-1:0] == '1);
    long_roll  = tick_i && (cnt_q[LONG_BITS-1:0] == '1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      short_q <= short_roll;
      long_q  <= long_roll;
    end
  end

  assign count_o     = cnt_q;
  assign irq_short_o = short_q;
  assign irq_long_o  = long_q;

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));
  // R4
  short_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |-> (cnt_q[SHORT_BITS-1:0] == '0));
  // R5
  long_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_q |-> short_q);
endmodule

// File: rtl/usec_timer_readport.sv
module usec_timer_readport
  import usec_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  rd_sel_e           sel;
  logic [HI_W-1:0]   hold_q;
  logic [DATA_W-1:0] data_q, data_d, hi_word;
  logic              valid_q;

  always_comb begin
    sel = SEL_NONE;
    if (rd_en_i && rd_addr_i == ADDR_LO) sel = SEL_LO;
    else if (rd_en_i && rd_addr_i == ADDR_HI) sel = SEL_HI;
  end

  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = hold_q;
    unique case (sel)
      SEL_LO:  data_d = count_i[DATA_W-1:0];
      SEL_HI:  data_d = hi_word;
      default: data_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= data_d;
      if (sel == SEL_LO) hold_q <= count_i[CNT_W-1:DATA_W];
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && rd_addr_i == ADDR_LO) |=> $stable(hold_q));
  // R8
  hi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == ADDR_HI) |=> (rd_data_o[DATA_W-1:HI_W] == '0));
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              irq_short_o,
  output logic              irq_long_o
);
  logic [CNT_W-1:0] count;

  usec_timer_counter #(
    .CNT_W(CNT_W), .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_o(count),
    .irq_short_o(irq_short_o), .irq_long_o(irq_long_o)
  );

  usec_timer_readport #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_readport (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .count_i(count), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );
endmodule

// File: tb/usec_timer_bench.sv
`timescale 1ns/1ps
module usec_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid, irq_s, irq_l;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_cnt = '0;
  logic [3:0]  m_hold = '0;

  always #2.5 clk = ~clk;

  usec_timer u_usec_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .irq_short_o(irq_s), .irq_long_o(irq_l)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a,
                                          input logic [11:0] c,
                                          input logic [3:0] h);
    if (a == 8'h24) return c[7:0];
    if (a == 8'h25) return {4'b0000, h};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check outputs at the following negedge.
  task automatic step(input logic t, input logic r, input logic [7:0] a);
    logic es, el;
    logic [7:0] ed;
    tick = t; rd_en = r; rd_addr = a;
    es = t && (m_cnt[6:0] == 7'h7F);
    el = t && (m_cnt[9:0] == 10'h3FF);
    ed = exp_read(a, m_cnt, m_hold);
    if (r && a == 8'h24) m_hold = m_cnt[11:8];
    if (t) m_cnt = m_cnt + 12'd1;
    @(posedge clk);
    @(negedge clk);
    check("R4 irq_short", {7'b0, irq_s}, {7'b0, es});
    check("R5 irq_long",  {7'b0, irq_l}, {7'b0, el});
    check("R10 rd_valid", {7'b0, rd_valid}, {7'b0, r});
    if (r) begin
      if (a == 8'h24)      check("R6 R2 R3 low read", rd_data, ed);
      else if (a == 8'h25) check("R7 R8 high read", rd_data, ed);
      else                 check("R9 other read", rd_data, ed);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 irq_short", {7'b0, irq_s}, 8'h00);
    check("R1 irq_long", {7'b0, irq_l}, 8'h00);
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 8'h25);            // R1 hold is zero
    step(1'b0, 1'b1, 8'h24);            // R1 count is zero
    // R2 idle cycles keep the count
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h24);
    // R8 hold survives many ticks and other reads
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'h24);            // read with tick in same cycle
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h77);            // R9
    step(1'b0, 1'b1, 8'h25);            // R8 stale nibble
    // R10 back-to-back reads
    step(1'b1, 1'b1, 8'h24);
    step(1'b1, 1'b1, 8'h25);
    step(1'b1, 1'b1, 8'h00);
    // R3 drive to 0xFFF and across the wrap
    while (m_cnt != 12'hFFF) step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h24);
    step(1'b0, 1'b1, 8'h25);
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h24);
    step(1'b0, 1'b1, 8'h25);
    // Constrained random mix
    for (int i = 0; i < 12000; i++) begin
      logic t, r;
      logic [7:0] a;
      int unsigned k;
      t = ($urandom % 4) != 0;
      r = ($urandom % 5) == 0;
      k = $urandom % 8;
      a = (k < 3) ? 8'h24 : (k < 6) ? 8'h25 : 8'($urandom);
      step(t, r, a);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule